// File: doc/BRIEF.md
# Interrupt Identification and Dispatch Controller

This block gathers the interrupt flags of a set of peripheral functions. Each function owns several flag sources. Every source is masked by its own enable, and the surviving sources of a function are ORed into one identification bit. The identification bits are registered on the rising clock edge. They are read through three read-only 16-bit registers, one per peripheral module group, chosen by a two-bit select.

The same identification bits drive an entry sequencer for a small CPU. When the CPU's global interrupt enable is set and any identification bit is set, the sequencer runs a hardware-generated long call. It stalls the CPU, pushes the return address onto the stack and loads the program counter with a per-function vector. If the instruction in flight raises an exception window, one further instruction is allowed to execute before the takeover.

At vectoring time the sequencer emits a one-cycle acknowledge. The CPU uses that pulse to clear its global enable, which prevents nested entry. Flags are never cleared here; a request stays pending for as long as an enabled flag remains set.

Top module: `irq_ident_dispatch`

## Requirements
- R1: Function f's identification bit is the OR over its SRC_W sources of (flag AND enable), with the sources of f at src_flag_i[f*SRC_W +: SRC_W]. It is registered on the rising edge and is visible in the cycle after the edge that sampled it.
- R2: With rd_sel_i = 0 the read data holds external pin functions 0 to 6 (function indices 0..6) in bits 0 to 6, the supply monitor (function 7) in bit 7 and the I2C master (function 8) in bit 8. Bits 15:9 read 0.
- R3: With rd_sel_i = 1 the read data holds the ADC (function 9) in bit 0, the three-wire port (function 10) in bit 1 and the SPI slave (function 11) in bit 2, with bits 15:3 reading 0. With rd_sel_i = 2 it holds the SPI master (function 12) in bit 0 and the fast comparator (function 13) in bit 1, with bits 15:2 reading 0. With rd_sel_i = 3 it reads all zero.
- R4: After reset all identification bits read 0 and stall_o, push_req_o, pc_load_o and ack_o are low.
- R5: Let c be the first cycle in which an identification bit is visible, with glb_en_i high and exc_win_i low. Cycle c is not stalled. In cycle c+1 stall_o and push_req_o are high. In cycle c+2 stall_o, pc_load_o and ack_o are high. In cycle c+3 stall_o is low.
- R6: If exc_win_i is high in cycle c, then cycle c+1 is neither stalled nor pushing, push_req_o rises in cycle c+2 and pc_load_o rises in cycle c+3.
- R7: push_data_o equals the pc_i value of the cycle just before the push cycle.
- R8: The lowest-indexed identification bit set at decision time (cycle c) wins. pc_vec_o = VEC_BASE + index*VEC_STEP and ack_id_o = index. Both keep that value even if the flags change later in the sequence.
- R9: While glb_en_i is low no sequence starts. A request held pending starts its sequence in the cycle after glb_en_i goes high.
- R10: ack_o lasts exactly one cycle, and no new sequence starts while one is running. After the acknowledge, with the global enable cleared, no further push occurs even though the flags stay set.
- R11: A flag whose enable is low has no effect on the identification bits or on the vector chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| src_flag_i | input | 14*SRC_W | Raw interrupt flags, SRC_W per function |
| src_en_i | input | 14*SRC_W | Per-source enables |
| glb_en_i | input | 1 | CPU global interrupt enable |
| exc_win_i | input | 1 | Exception window from the instruction in flight |
| pc_i | input | PC_W | Current program counter |
| rd_sel_i | input | 2 | Identification register select |
| rd_data_o | output | 16 | Identification register read data |
| stall_o | output | 1 | CPU stalled by the entry sequence |
| ack_o | output | 1 | One-cycle acknowledge at vectoring |
| ack_id_o | output | 4 | Index of the function being serviced |
| push_req_o | output | 1 | Stack push request |
| push_data_o | output | PC_W | Return address to push |
| pc_load_o | output | 1 | Load the program counter with pc_vec_o |
| pc_vec_o | output | PC_W | Interrupt vector address |

## Verification
The hardest case to reach from the ports is the deferred entry. The exception window must be high in exactly the cycle the sequencer decides, and the program counter must move during the deferral cycle, so that the pushed address shows which cycle was captured. The bench raises the window together with the flag and drops it in the deferral cycle while stepping pc_i. A second corner changes the flags to a higher-priority source after the decision, to show that the latched vector does not follow them.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NFUNC = 14;
    localparam int REG_W = 16;
    localparam int IDX_W = $clog2(NFUNC);
    localparam int NGRP  = 3;

    // function index map (also priority order: lower index wins)
    localparam int F_PIN0    = 0;
    localparam int F_SUPPLY  = 7;
    localparam int F_I2C_MST = 8;
    localparam int F_ADC     = 9;
    localparam int F_TWIRE   = 10;
    localparam int F_SPI_SLV = 11;
    localparam int F_SPI_MST = 12;
    localparam int F_FASTCMP = 13;

    // register groups: first function index and width of each
    localparam int GRP_LO [NGRP] = '{0, 9, 12};
    localparam int GRP_N  [NGRP] = '{9, 3, 2};

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DEFER = 2'd1,
        ST_PUSH  = 2'd2,
        ST_LOAD  = 2'd3
    } seq_st_e;

    typedef struct packed {
        logic [NFUNC-1:0] id;
    } idreg_t;
endpackage

// File: rtl/irq_fold.sv
module irq_fold
    import irq_pkg::*;
#(
    parameter int SRC_W = 4
) (
    input  logic [NFUNC*SRC_W-1:0] flag_i,
    input  logic [NFUNC*SRC_W-1:0] en_i,
    output logic [NFUNC-1:0]       fn_req_o
);
    for (genvar f = 0; f < NFUNC; f++) begin : g_fn
        assign fn_req_o[f] = |(flag_i[f*SRC_W +: SRC_W] & en_i[f*SRC_W +: SRC_W]);
    end
endmodule

// File: rtl/irq_idreg.sv
module irq_idreg
    import irq_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic [NFUNC-1:0] fn_req_i,
    input  logic [1:0]       rd_sel_i,
    output logic [NFUNC-1:0] id_o,
    output logic [REG_W-1:0] rd_data_o
);
    idreg_t r_d, r_q;
    logic [REG_W-1:0] grp_word [NGRP];

    always_comb begin
        r_d    = r_q;
        r_d.id = fn_req_i;
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) r_q <= '0;
        else          r_q <= r_d;
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign grp_word[g] = {{(REG_W-GRP_N[g]){1'b0}}, r_q.id[GRP_LO[g] +: GRP_N[g]]};
    end

    always_comb begin
        case (rd_sel_i)
            2'd0:    rd_data_o = grp_word[0];
            2'd1:    rd_data_o = grp_word[1];
            2'd2:    rd_data_o = grp_word[2];
            default: rd_data_o = '0;
        endcase
    end

    assign id_o = r_q.id;
endmodule

// File: rtl/irq_prio.sv
module irq_prio
    import irq_pkg::*;
(
    input  logic [NFUNC-1:0] req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = NFUNC-1; i >= 0; i--) begin
            if (req_i[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_seq.sv
module irq_seq
    import irq_pkg::*;
#(
    parameter int PC_W     = 16,
    parameter int VEC_BASE = 256,
    parameter int VEC_STEP = 4
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             any_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             glb_en_i,
    input  logic             exc_win_i,
    input  logic [PC_W-1:0]  pc_i,
    output logic             stall_o,
    output logic             ack_o,
    output logic [IDX_W-1:0] ack_id_o,
    output logic             push_req_o,
    output logic [PC_W-1:0]  push_data_o,
    output logic             pc_load_o,
    output logic [PC_W-1:0]  pc_vec_o
);
    typedef struct packed {
        seq_st_e          st;
        logic [PC_W-1:0]  ret;
        logic [IDX_W-1:0] sel;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            ST_IDLE: begin
                if (glb_en_i && any_i) begin
                    s_d.sel = idx_i;
                    if (exc_win_i) begin
                        s_d.st = ST_DEFER;
                    end else begin
                        s_d.st  = ST_PUSH;
                        s_d.ret = pc_i;
                    end
                end
            end
            ST_DEFER: begin
                s_d.ret = pc_i;
                s_d.st  = ST_PUSH;
            end
            ST_PUSH: s_d.st = ST_LOAD;
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) s_q <= '{st: ST_IDLE, ret: '0, sel: '0};
        else          s_q <= s_d;
    end

    assign stall_o     = (s_q.st == ST_PUSH) || (s_q.st == ST_LOAD);
    assign push_req_o  = (s_q.st == ST_PUSH);
    assign push_data_o = s_q.ret;
    assign pc_load_o   = (s_q.st == ST_LOAD);
    assign ack_o       = (s_q.st == ST_LOAD);
    assign ack_id_o    = s_q.sel;
    assign pc_vec_o    = PC_W'(VEC_BASE) + PC_W'(s_q.sel) * PC_W'(VEC_STEP);
endmodule

// File: rtl/irq_ident_dispatch.sv
module irq_ident_dispatch
    import irq_pkg::*;
#(
    parameter int SRC_W    = 4,
    parameter int PC_W     = 16,
    parameter int VEC_BASE = 256,
    parameter int VEC_STEP = 4
) (
    input  logic                    clk_i,
    input  logic                    rst_n_i,
    input  logic [NFUNC*SRC_W-1:0]  src_flag_i,
    input  logic [NFUNC*SRC_W-1:0]  src_en_i,
    input  logic                    glb_en_i,
    input  logic                    exc_win_i,
    input  logic [PC_W-1:0]         pc_i,
    input  logic [1:0]              rd_sel_i,
    output logic [REG_W-1:0]        rd_data_o,
    output logic                    stall_o,
    output logic                    ack_o,
    output logic [IDX_W-1:0]        ack_id_o,
    output logic                    push_req_o,
    output logic [PC_W-1:0]         push_data_o,
    output logic                    pc_load_o,
    output logic [PC_W-1:0]         pc_vec_o
);
    logic [NFUNC-1:0] fn_req;
    logic [NFUNC-1:0] id_q;
    logic             any_req;
    logic [IDX_W-1:0] win_idx;

    irq_fold #(.SRC_W(SRC_W)) u_fold (
        .flag_i   (src_flag_i),
        .en_i     (src_en_i),
        .fn_req_o (fn_req)
    );

    irq_idreg u_idreg (
        .clk_i     (clk_i),
        .rst_n_i   (rst_n_i),
        .fn_req_i  (fn_req),
        .rd_sel_i  (rd_sel_i),
        .id_o      (id_q),
        .rd_data_o (rd_data_o)
    );

    irq_prio u_prio (
        .req_i (id_q),
        .any_o (any_req),
        .idx_o (win_idx)
    );

    irq_seq #(
        .PC_W     (PC_W),
        .VEC_BASE (VEC_BASE),
        .VEC_STEP (VEC_STEP)
    ) u_seq (
        .clk_i       (clk_i),
        .rst_n_i     (rst_n_i),
        .any_i       (any_req),
        .idx_i       (win_idx),
        .glb_en_i    (glb_en_i),
        .exc_win_i   (exc_win_i),
        .pc_i        (pc_i),
        .stall_o     (stall_o),
        .ack_o       (ack_o),
        .ack_id_o    (ack_id_o),
        .push_req_o  (push_req_o),
        .push_data_o (push_data_o),
        .pc_load_o   (pc_load_o),
        .pc_vec_o    (pc_vec_o)
    );
endmodule

// File: rtl/irq_chk.sv
module irq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        stall,
    input logic        ack,
    input logic        push_req,
    input logic        pc_load,
    input logic [1:0]  rd_sel,
    input logic [15:0] rd_data
);
    p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    p_push_then_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        push_req |=> (pc_load && ack && stall));

    p_push_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        push_req |=> !push_req);

    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !stall);

    p_load_after_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> $past(push_req));

    p_reserved_grp0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == 2'd0) |-> (rd_data[15:9] == 7'd0));

    p_reserved_grp1_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == 2'd1) |-> (rd_data[15:3] == 13'd0));
endmodule

bind irq_ident_dispatch irq_chk u_chk (
    .clk      (clk_i),
    .rst_n    (rst_n_i),
    .stall    (stall_o),
    .ack      (ack_o),
    .push_req (push_req_o),
    .pc_load  (pc_load_o),
    .rd_sel   (rd_sel_i),
    .rd_data  (rd_data_o)
);

// File: tb/sim_irq_ident_dispatch.sv
`timescale 1ns/1ps
module sim_irq_ident_dispatch;
    localparam int SRC_W = 4;
    localparam int PC_W  = 16;
    localparam int VB    = 256;
    localparam int VS    = 4;
    localparam int FW    = 14*SRC_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [FW-1:0]   flags = '0;
    logic [FW-1:0]   ens = '0;
    logic            glb = 1'b0;
    logic            exc = 1'b0;
    logic [PC_W-1:0] pc = '0;
    logic [1:0]      sel = '0;
    logic [15:0]     rd;
    logic            stall, ack, push, load;
    logic [3:0]      ack_id;
    logic [PC_W-1:0] pdata, vec;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    irq_ident_dispatch #(.SRC_W(SRC_W), .PC_W(PC_W), .VEC_BASE(VB), .VEC_STEP(VS)) u0 (
        .clk_i(clk), .rst_n_i(rst_n), .src_flag_i(flags), .src_en_i(ens),
        .glb_en_i(glb), .exc_win_i(exc), .pc_i(pc), .rd_sel_i(sel),
        .rd_data_o(rd), .stall_o(stall), .ack_o(ack), .ack_id_o(ack_id),
        .push_req_o(push), .push_data_o(pdata), .pc_load_o(load), .pc_vec_o(vec)
    );

    // {flags, enables, select, expected read data}
    localparam logic [129:0] TBL [10] = '{
        {56'hFF_FFFF_FFFF_FFFF, 56'hFF_FFFF_FFFF_FFFF, 2'd0, 16'h01FF},
        {56'hFF_FFFF_FFFF_FFFF, 56'hFF_FFFF_FFFF_FFFF, 2'd1, 16'h0007},
        {56'hFF_FFFF_FFFF_FFFF, 56'hFF_FFFF_FFFF_FFFF, 2'd2, 16'h0003},
        {56'hFF_FFFF_FFFF_FFFF, 56'hFF_FFFF_FFFF_FFFF, 2'd3, 16'h0000},
        {56'hFF_FFFF_FFFF_FFFF, 56'h00_0000_0000_0000, 2'd0, 16'h0000},
        {56'h0000_0040_0000_00, 56'hFF_FFFF_FFFF_FFFF, 2'd0, 16'h0080},
        {56'h0000_8000_0000_00, 56'hFF_FFFF_FFFF_FFFF, 2'd1, 16'h0001},
        {56'h0000_0040_0000_00, 56'hFFFF_FFBF_FFFF_FF, 2'd0, 16'h0000},
        {56'h1000_0000_0010_00, 56'hFF_FFFF_FFFF_FFFF, 2'd2, 16'h0002},
        {56'h1000_0000_0010_00, 56'hFF_FFFF_FFFF_FFFF, 2'd0, 16'h0008}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [PC_W-1:0] vexp(input int idx);
        return PC_W'(VB + idx*VS);
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R4: reset state
        chk(rd == 16'h0, "R4 id", 32'(rd), 0);
        chk({stall, push, load, ack} == 4'b0, "R4 ctl", 32'({stall, push, load, ack}), 0);
        rst_n = 1'b1;
        step();
        chk(rd == 16'h0, "R4 after release", 32'(rd), 0);

        // R1 R2 R3 R11: table walk, global enable off
        for (int i = 0; i < 10; i++) begin
            flags = TBL[i][129:74];
            ens   = TBL[i][73:18];
            sel   = TBL[i][17:16];
            step();
            chk(rd == TBL[i][15:0], $sformatf("R1/R2/R3/R11 row %0d", i), 32'(rd), 32'(TBL[i][15:0]));
            chk(push == 1'b0, "R9 no push while disabled", 32'(push), 0);
        end
        flags = '0;
        ens   = '1;
        sel   = 2'd0;
        step();

        // R5 R7 R8 R10: plain entry, supply monitor (7) vs SPI slave (11)
        glb = 1'b1;
        pc  = 16'h1234;
        flags[7*SRC_W]      = 1'b1;
        flags[11*SRC_W + 1] = 1'b1;
        step();
        chk(rd == 16'h0080, "R1 visible next cycle", 32'(rd), 32'h80);
        chk(stall == 1'b0 && push == 1'b0, "R5 cycle c not stalled", 32'({stall, push}), 0);
        step();
        chk(push && stall, "R5 push cycle", 32'({stall, push}), 3);
        chk(pdata == 16'h1234, "R7 return address", 32'(pdata), 32'h1234);
        pc = 16'h5678;
        step();
        chk(load && ack && stall, "R5 load cycle", 32'({stall, load, ack}), 7);
        chk(vec == vexp(7), "R8 vector", 32'(vec), 32'(vexp(7)));
        chk(ack_id == 4'd7, "R8 ack id", 32'(ack_id), 7);
        glb = 1'b0;
        step();
        chk(!stall && !ack && !push, "R10 released, single ack", 32'({stall, ack, push}), 0);
        step();
        chk(!push && !stall, "R10 no reentry", 32'({push, stall}), 0);
        flags = '0;
        step();

        // R6 R7: exception window defers entry by one cycle
        glb = 1'b1;
        exc = 1'b1;
        pc  = 16'h2000;
        flags[12*SRC_W + 2] = 1'b1;
        step();
        chk(!push && !stall, "R6 cycle c", 32'({push, stall}), 0);
        step();
        chk(!push && !stall, "R6 deferred cycle runs", 32'({push, stall}), 0);
        exc = 1'b0;
        pc  = 16'h2002;
        step();
        chk(push && stall, "R6 push delayed", 32'({push, stall}), 3);
        chk(pdata == 16'h2002, "R7 deferred return address", 32'(pdata), 32'h2002);
        step();
        chk(load && vec == vexp(12), "R6 load vector", 32'(vec), 32'(vexp(12)));
        glb = 1'b0;
        flags = '0;
        step();

        // R9: pending request waits for global enable
        flags[0] = 1'b1;
        for (int k = 0; k < 3; k++) begin
            step();
            chk(!push && !stall, "R9 held off", 32'({push, stall}), 0);
        end
        glb = 1'b1;
        step();
        chk(push == 1'b1, "R9 entry after enable", 32'(push), 1);
        step();
        chk(vec == vexp(0), "R9 vector", 32'(vec), 32'(vexp(0)));
        glb = 1'b0;
        flags = '0;
        step();

        // R11 R8: disabled lower source skipped; vector latched at decision
        ens = '1;
        ens[2*SRC_W +: SRC_W] = '0;
        flags[2*SRC_W] = 1'b1;
        flags[5*SRC_W + 3] = 1'b1;
        glb = 1'b1;
        step();
        step();
        chk(push == 1'b1, "R11 push", 32'(push), 1);
        flags[1*SRC_W] = 1'b1;
        step();
        chk(vec == vexp(5), "R8/R11 latched vector", 32'(vec), 32'(vexp(5)));
        chk(ack_id == 4'd5, "R8 latched id", 32'(ack_id), 5);
        glb = 1'b0;
        flags = '0;
        step();

        summary();
        $finish;
    end
endmodule